// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block steps a 16-input analog multiplexer through a programmable window of channels and turns each conversion into a 16-bit word tagged with the channel it came from. Software configures it through a single word-wide write port. That port selects one of four targets: the scan window, the per-channel range entry, the trigger enables, or a data-port strobe that acts as the software trigger. Conversions are started by the software strobe, a pacer tick or an external trigger, each gated by its own enable bit.

For every conversion the block presents the channel number and that channel's stored gain code, polarity and input mode to the analog front end. It pulses a start strobe, waits a fixed number of clocks for the converter, and then captures the converter's 12-bit result. It pushes the tagged sample as a one-cycle strobe toward a downstream buffer. Differential inputs occupy an even/odd pair, so the scan steps over the odd partner of a differential channel. After the stop channel the scan returns to the start channel.

Top module: `adc_scan_seq`

## Requirements
- R1: A write with select code 0 loads the scan start channel from data bits 3:0 and the stop channel from bits 11:8, and moves the current scan position to the new start channel.
- R2: With single-ended channels the scan visits start, start+1, … up to stop (counting modulo 16), then wraps to start. Equal start and stop convert one fixed channel every time.
- R3: A write with select code 1 stores a range entry for the current scan position: bit 5 differential, bit 4 unipolar, bits 2:0 gain code. The entry of the channel on `mux_sel` is driven on `fe_diff`, `fe_unipolar` and `fe_gain`, and each channel keeps its own entry.
- R4: The differential bit written for an odd channel is ignored, so that channel stays single-ended.
- R5: After converting a differential (even) channel, the scan advances by two. If the skipped partner is the stop channel, the scan wraps to start.
- R6: A write with select code 2 sets the trigger enables: bit 0 lets a write with select code 3 start a conversion, bit 1 lets `pacer_tick` start one, and bit 2 lets `ext_trig` start one. A trigger whose enable is clear has no effect.
- R7: An accepted trigger raises `conv_start` for one cycle after the trigger edge. `smp_push` rises for one cycle exactly LAT clocks after that, with `conv_result` sampled at the same edge.
- R8: A pushed sample holds the converted channel in bits 15:12 and the conversion value in bits 11:0.
- R9: A trigger that arrives while a conversion is in progress is ignored.
- R10: A select-code-2 write whose bits 2:0 are all zero stops all conversions and discards an unfinished one, with no push, and keeps `cnt_clk_ext` unchanged. Any other select-code-2 write loads `cnt_clk_ext` from bit 6.
- R11: A window write in the same cycle as an accepted trigger converts the newly written start channel, and the scan continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 window, 1 range, 2 control, 3 software trigger |
| wr_data | input | 16 | Write data |
| pacer_tick | input | 1 | Pacer trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| conv_result | input | 12 | Converter result, valid LAT clocks after start |
| mux_sel | output | 4 | Channel presented to the multiplexer |
| fe_gain | output | 3 | Gain code of the presented channel |
| fe_unipolar | output | 1 | Unipolar mode of the presented channel |
| fe_diff | output | 1 | Differential mode of the presented channel |
| conv_start | output | 1 | One-cycle conversion start strobe |
| smp_push | output | 1 | One-cycle sample valid strobe |
| smp_data | output | 16 | Tagged sample |
| cnt_clk_ext | output | 1 | Counter clock source select |

## Verification
The sharpest collision is a window write landing in the same clock as an enabled pacer tick. The write moves the scan position while the trigger claims the channel to convert. The bench drives both for a single cycle partway through a scan, then requires that the pushed tag is the freshly written start channel and that the following conversion is the next channel after it. A second overlap, a trigger arriving during an active conversion, is provoked by holding the pacer high for the whole conversion window and requiring exactly one start and one push.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int GAIN_W = 3;

    typedef enum logic [1:0] {
        SEL_WINDOW = 2'd0,
        SEL_RANGE  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_SWTRIG = 2'd3
    } wr_target_e;

    typedef struct packed {
        logic              diff;
        logic              uni;
        logic [GAIN_W-1:0] gain;
    } chan_cfg_t;

endpackage

// File: rtl/adc_range_bank.sv
module adc_range_bank
    import adc_scan_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] wr_ch,
    input  chan_cfg_t     wr_cfg,
    input  logic [CW-1:0] rd_a_ch,
    output chan_cfg_t     rd_a_cfg,
    input  logic [CW-1:0] rd_b_ch,
    output chan_cfg_t     rd_b_cfg
);

    chan_cfg_t cfg_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_entry
        chan_cfg_t entry_d;
        // Odd channels can never be the positive leg of a pair.
        if ((g % 2) == 1) begin : g_odd
            assign entry_d = '{diff: 1'b0, uni: wr_cfg.uni, gain: wr_cfg.gain};
        end else begin : g_even
            assign entry_d = wr_cfg;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (we && (wr_ch == CW'(g))) begin
                cfg_q[g] <= entry_d;
            end
        end
    end

    assign rd_a_cfg = cfg_q[rd_a_ch];
    assign rd_b_cfg = cfg_q[rd_b_ch];

endmodule

// File: rtl/adc_next_chan.sv
module adc_next_chan #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] win_lo,
    input  logic [CW-1:0] win_hi,
    input  logic          is_diff,
    output logic [CW-1:0] nxt
);

    logic [CW-1:0] plus_one;
    logic          at_end;

    always_comb begin
        plus_one = cur + CW'(1);
        at_end   = (cur == win_hi) || (is_diff && (plus_one == win_hi));
        if (at_end) begin
            nxt = win_lo;
        end else if (is_diff) begin
            nxt = cur + CW'(2);
        end else begin
            nxt = plus_one;
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 12,
    parameter int WW  = 16,
    parameter int LAT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [WW-1:0]                wr_data,
    input  logic                         pacer_tick,
    input  logic                         ext_trig,
    input  logic [DW-1:0]                conv_result,
    output logic [$clog2(NCH)-1:0]       mux_sel,
    output logic [GAIN_W-1:0]            fe_gain,
    output logic                         fe_unipolar,
    output logic                         fe_diff,
    output logic                         conv_start,
    output logic                         smp_push,
    output logic [$clog2(NCH)+DW-1:0]    smp_data,
    output logic                         cnt_clk_ext
);

    localparam int CW    = $clog2(NCH);
    localparam int SW    = CW + DW;
    localparam int CNTW  = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int HI_LSB = 8;
    localparam int EN_W  = 3;
    localparam int CLKSEL_BIT = 6;

    typedef struct packed {
        logic [CW-1:0]   cur;
        logic [CW-1:0]   win_lo;
        logic [CW-1:0]   win_hi;
        logic [EN_W-1:0] trig_en;
        logic            clk_ext;
        logic            busy;
        logic [CNTW-1:0] wait_cnt;
        logic [CW-1:0]   conv_ch;
        logic            start_pls;
        logic            push;
        logic [SW-1:0]   sample;
    } seq_state_t;

    seq_state_t q, d;

    logic          win_wr, rng_wr, ctrl_wr, sw_wr;
    logic          halt, trig;
    logic [CW-1:0] base_ch, base_lo, base_hi, step_ch;
    chan_cfg_t     fe_cfg, base_cfg, wr_cfg;

    assign win_wr  = wr_en && (wr_sel == SEL_WINDOW);
    assign rng_wr  = wr_en && (wr_sel == SEL_RANGE);
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign sw_wr   = wr_en && (wr_sel == SEL_SWTRIG);

    assign base_ch = win_wr ? wr_data[CW-1:0] : q.cur;
    assign base_lo = win_wr ? wr_data[CW-1:0] : q.win_lo;
    assign base_hi = win_wr ? wr_data[HI_LSB +: CW] : q.win_hi;

    assign wr_cfg = '{diff: wr_data[5], uni: wr_data[4], gain: wr_data[GAIN_W-1:0]};

    adc_range_bank #(.NCH(NCH)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rng_wr),
        .wr_ch    (q.cur),
        .wr_cfg   (wr_cfg),
        .rd_a_ch  (mux_sel),
        .rd_a_cfg (fe_cfg),
        .rd_b_ch  (base_ch),
        .rd_b_cfg (base_cfg)
    );

    adc_next_chan #(.CW(CW)) i_next (
        .cur     (base_ch),
        .win_lo  (base_lo),
        .win_hi  (base_hi),
        .is_diff (base_cfg.diff),
        .nxt     (step_ch)
    );

    always_comb begin
        d           = q;
        d.start_pls = 1'b0;
        d.push      = 1'b0;

        halt = ctrl_wr && (wr_data[EN_W-1:0] == '0);
        trig = ((sw_wr && q.trig_en[0]) ||
                (pacer_tick && q.trig_en[1]) ||
                (ext_trig && q.trig_en[2])) && !halt;

        if (win_wr) begin
            d.win_lo = wr_data[CW-1:0];
            d.win_hi = wr_data[HI_LSB +: CW];
            d.cur    = wr_data[CW-1:0];
        end

        if (ctrl_wr) begin
            d.trig_en = wr_data[EN_W-1:0];
            if (!halt) begin
                d.clk_ext = wr_data[CLKSEL_BIT];
            end
        end

        if (q.busy) begin
            if (q.wait_cnt == '0) begin
                d.busy   = 1'b0;
                d.push   = !halt;
                d.sample = {q.conv_ch, conv_result};
            end else begin
                d.wait_cnt = q.wait_cnt - CNTW'(1);
            end
        end else if (trig) begin
            d.busy      = 1'b1;
            d.wait_cnt  = CNTW'(LAT - 1);
            d.conv_ch   = base_ch;
            d.start_pls = 1'b1;
            d.cur       = step_ch;
        end

        if (halt) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mux_sel     = q.busy ? q.conv_ch : q.cur;
    assign fe_gain     = fe_cfg.gain;
    assign fe_unipolar = fe_cfg.uni;
    assign fe_diff     = fe_cfg.diff;
    assign conv_start  = q.start_pls;
    assign smp_push    = q.push;
    assign smp_data    = q.sample;
    assign cnt_clk_ext = q.clk_ext;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[WW-1:HI_LSB+CW], wr_data[HI_LSB-1:CLKSEL_BIT+1],
                              wr_data[3]};

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NCH = 16,
    parameter int DW  = 12,
    parameter int WW  = 16,
    parameter int LAT = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [1:0]                wr_sel,
    input logic [WW-1:0]             wr_data,
    input logic [$clog2(NCH)-1:0]    mux_sel,
    input logic                      fe_diff,
    input logic                      conv_start,
    input logic                      smp_push,
    input logic [$clog2(NCH)+DW-1:0] smp_data,
    input logic                      cnt_clk_ext
);

    localparam int CW = $clog2(NCH);
    localparam int SW = CW + DW;

    logic          halt_wr;
    logic          act;
    int            age;
    logic [CW-1:0] tag;

    assign halt_wr = wr_en && (wr_sel == 2'd2) && (wr_data[2:0] == 3'b000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= 1'b0;
            age <= 0;
            tag <= '0;
        end else begin
            if (conv_start) begin
                act <= 1'b1;
                age <= 1;
                tag <= mux_sel;
            end else if (act) begin
                age <= age + 1;
            end
            if (smp_push || halt_wr) begin
                act <= 1'b0;
            end
        end
    end

    logic unused_chk;
    assign unused_chk = ^wr_data[WW-1:3];

    // R7
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_push |=> !smp_push);

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R7
    push_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_push |-> (act && age == LAT));

    // R8
    push_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_push |-> (smp_data[SW-1 -: CW] == tag));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !act);

    // R9
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && age < LAT && !conv_start) |-> $stable(mux_sel));

    // R4
    odd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel[0] |-> !fe_diff);

    // R10
    clk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> $stable(cnt_clk_ext));

    // R10
    halt_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> !smp_push);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .DW(DW), .WW(WW), .LAT(LAT)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .mux_sel     (mux_sel),
    .fe_diff     (fe_diff),
    .conv_start  (conv_start),
    .smp_push    (smp_push),
    .smp_data    (smp_data),
    .cnt_clk_ext (cnt_clk_ext)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        pacer_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic [11:0] conv_result = '0;
    logic [3:0]  mux_sel;
    logic [2:0]  fe_gain;
    logic        fe_unipolar, fe_diff, conv_start, smp_push, cnt_clk_ext;
    logic [15:0] smp_data;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit bdiff [16];

    always #2 clk = ~clk;

    adc_scan_seq #(.LAT(LAT)) i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .conv_result(conv_result),
        .mux_sel(mux_sel), .fe_gain(fe_gain), .fe_unipolar(fe_unipolar), .fe_diff(fe_diff),
        .conv_start(conv_start), .smp_push(smp_push), .smp_data(smp_data),
        .cnt_clk_ext(cnt_clk_ext)
    );

    task automatic chk(input bit c, input string r, input int act, input int exp);
        checks++;
        if (!c) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [3:0] bnext(input logic [3:0] ch, input logic [3:0] lo,
                                         input logic [3:0] hi);
        if (ch == hi || (bdiff[ch] && 4'(ch + 1) == hi)) return lo;
        return bdiff[ch] ? 4'(ch + 2) : 4'(ch + 1);
    endfunction

    // Drives one cycle at a negedge; returns at the negedge after the edge.
    task automatic wr(input logic [1:0] sel, input logic [15:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_win(input logic [3:0] lo, input logic [3:0] hi);
        wr(2'd0, {4'h0, hi, 4'h0, lo});
    endtask

    // kind: 0 software write, 1 pacer, 2 external
    task automatic fire(input int kind);
        if (kind == 0) wr(2'd3, 16'h0);
        else begin
            @(negedge clk);
            if (kind == 1) pacer_tick = 1'b1; else ext_trig = 1'b1;
            @(negedge clk);
            pacer_tick = 1'b0; ext_trig = 1'b0;
        end
    endtask

    // Called at the negedge right after the trigger edge.
    task automatic expect_conv(input logic [3:0] ch, input logic [11:0] val, input string r);
        bit timing_ok;
        logic [15:0] got;
        timing_ok = conv_start && (mux_sel == ch);
        got = '0;
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            if (k < LAT && (smp_push || conv_start)) timing_ok = 1'b0;
            if (k == LAT) begin
                if (!smp_push) timing_ok = 1'b0;
                got = smp_data;
            end
        end
        chk(timing_ok, "R7 start/push timing", int'(got), int'(ch));
        chk(got == {ch, val}, r, int'(got), int'({ch, val}));
    endtask

    task automatic conv(input int kind, input logic [3:0] ch, input string r);
        logic [11:0] v;
        v = 12'(ch * 73 + checks * 5 + 11);
        conv_result = v;
        fire(kind);
        expect_conv(ch, v, r);
    endtask

    task automatic quiet(input int n, input string r);
        int hits;
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (conv_start || smp_push) hits++;
        end
        chk(hits == 0, r, hits, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] ch;
        for (int c = 0; c < 16; c++) bdiff[c] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!smp_push && !conv_start && mux_sel == 0 && !cnt_clk_ext && fe_gain == 0,
            "reset state", int'({smp_push, conv_start, mux_sel}), 0);

        // R1 R2: every window, single-ended
        wr(2'd2, 16'h0001);
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 16; k++) begin
                logic [3:0] lo, hi;
                lo = 4'(s); hi = 4'(s + k);
                set_win(lo, hi);
                ch = lo;
                for (int i = 0; i < k + 3; i++) begin
                    conv(0, ch, "R2 window scan order");
                    ch = bnext(ch, lo, hi);
                end
            end
        end

        // R1: window write resets scan position
        set_win(4'd2, 4'd6);
        conv(0, 4'd2, "R1 window start");
        conv(0, 4'd3, "R1 step");
        set_win(4'd2, 4'd6);
        conv(0, 4'd2, "R1 position reset to start");

        // R3 R4: per-channel range entries
        for (int c = 0; c < 16; c++) begin
            set_win(4'(c), 4'(c));
            wr(2'd1, {10'h0, 1'b1, 1'(c ^ (c >> 1)), 1'b0, 3'(c)});
        end
        for (int c = 0; c < 16; c++) begin
            set_win(4'(c), 4'(c));
            chk(fe_gain == 3'(c) && fe_unipolar == 1'(c ^ (c >> 1)),
                "R3 stored gain/polarity", int'({fe_unipolar, fe_gain}),
                int'({1'(c ^ (c >> 1)), 3'(c)}));
            chk(fe_diff == ((c % 2) == 0), "R4 odd differential ignored",
                int'(fe_diff), int'((c % 2) == 0));
            bdiff[c] = ((c % 2) == 0);
        end

        // R5: differential skipping
        set_win(4'd0, 4'd7);
        ch = 4'd0;
        for (int i = 0; i < 6; i++) begin
            conv(0, ch, "R5 diff advance by two");
            ch = bnext(ch, 4'd0, 4'd7);
        end
        set_win(4'd3, 4'd9);
        ch = 4'd3;
        for (int i = 0; i < 6; i++) begin
            conv(0, ch, "R5 diff partner is stop");
            ch = bnext(ch, 4'd3, 4'd9);
        end

        // R6: trigger sources and gating
        set_win(4'd5, 4'd5);
        wr(2'd2, 16'h0002);
        conv(1, 4'd5, "R6 pacer trigger");
        fire(0);
        quiet(2 * LAT, "R6 software trigger disabled");
        fire(2);
        quiet(2 * LAT, "R6 external trigger disabled");
        wr(2'd2, 16'h0004);
        conv(2, 4'd5, "R6 external trigger");
        fire(1);
        quiet(2 * LAT, "R6 pacer disabled");

        // R9: triggers during conversion ignored
        begin
            int starts, pushes;
            starts = 0; pushes = 0;
            wr(2'd2, 16'h0002);
            @(negedge clk);
            pacer_tick = 1'b1;
            for (int k = 0; k < 3 * LAT; k++) begin
                @(negedge clk);
                if (k == LAT - 1) pacer_tick = 1'b0;
                starts += int'(conv_start);
                pushes += int'(smp_push);
            end
            chk(starts == 1 && pushes == 1, "R9 busy trigger ignored", starts * 16 + pushes, 17);
        end

        // R10: halt keeps clock select and drops the pending conversion
        wr(2'd2, 16'h0043);
        chk(cnt_clk_ext == 1'b1, "R10 clock select load", int'(cnt_clk_ext), 1);
        fire(1);
        wr(2'd2, 16'h0000);
        quiet(2 * LAT, "R10 halt discards conversion");
        chk(cnt_clk_ext == 1'b1, "R10 clock select kept", int'(cnt_clk_ext), 1);
        fire(0);
        fire(1);
        quiet(2 * LAT, "R10 halted ignores triggers");
        wr(2'd2, 16'h0002);
        chk(cnt_clk_ext == 1'b0, "R10 clock select cleared", int'(cnt_clk_ext), 0);

        // R11: window write coincides with pacer tick
        for (int c = 0; c < 16; c++) begin
            set_win(4'(c), 4'(c));
            wr(2'd1, 16'h0000);
            bdiff[c] = 1'b0;
        end
        set_win(4'd0, 4'd15);
        conv(1, 4'd0, "R11 lead-in");
        conv(1, 4'd1, "R11 lead-in");
        begin
            logic [11:0] v;
            v = 12'h5A3;
            conv_result = v;
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0907; pacer_tick = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; pacer_tick = 1'b0;
            expect_conv(4'd7, v, "R11 new start converted");
        end
        conv(1, 4'd8, "R11 scan continues");
        conv(1, 4'd9, "R11 wrap");
        conv(1, 4'd7, "R11 wrap to new start");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule